// File: doc/BRIEF.md
# Alternating-Reload PWM Timer

This block is a down-counter that produces a continuous pulse train without processor help. The counter moves by one step on each enable tick from an external prescaler. When a tick arrives while the count is zero, the counter reloads. Successive reloads alternate between two software-written values, first A, then B, then A again. The toggle enable is normally set, and then the output pin inverts on every reload. The A value therefore sets the duration of one output level and the B value sets the other.

Each reload source has its own sticky pending flag. Software clears a flag by pulsing the matching clear input. Each flag drives its own interrupt line, and that line is gated by its own enable. While the timer is stopped, software may preset the count to define the first period. Stopping the timer always sends the reload sequence back to A, so every restart begins with a reload from A.

Top module: `alt_reload_pwm`

## Requirements
- R1: After reset the count is 0, the output pin is 0, both pending flags and both interrupt lines are 0, and the counter stays idle until `run` is raised.
- R2: While `run` is 1, a cycle with `tick` 1 and a nonzero count lowers the count by one. A cycle with `tick` 0 leaves the count unchanged.
- R3: A tick at count 0 is an underflow, and the reload takes place on that same tick. A reload value of N therefore gives a phase of N+1 ticks.
- R4: Reloads alternate strictly between source A (`reload_a`) and source B (`reload_b`), and the sequence begins with A.
- R5: Any cycle with `run` at 0 returns the sequence to A, so the first underflow after a restart loads A.
- R6: With `toggle_en` set to 1, `pwm_out` inverts on every underflow. With `toggle_en` at 0, and in every cycle with `run` at 0, `pwm_out` holds its level.
- R7: A reload from A sets `pend_a` and a reload from B sets `pend_b`. A flag stays set until its clear input (`clr_a` or `clr_b`) is 1 at a clock edge. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_a` equals `pend_a AND ien_a`, and `irq_b` equals `pend_b AND ien_b`.
- R9: With `run` at 0, a pulse on `load_en` writes `load_value` into the count. With `run` at 1, `load_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| run | input | 1 | 1 = counting, 0 = stopped |
| toggle_en | input | 1 | Invert the output on every underflow |
| reload_a | input | 16 | Reload value A (phase entered first) |
| reload_b | input | 16 | Reload value B |
| load_en | input | 1 | Preset strobe, honoured only while stopped |
| load_value | input | 16 | Preset value for the count |
| clr_a | input | 1 | Clear strobe for pending flag A |
| clr_b | input | 1 | Clear strobe for pending flag B |
| ien_a | input | 1 | Interrupt enable for source A |
| ien_b | input | 1 | Interrupt enable for source B |
| count | output | 16 | Current count |
| pwm_out | output | 1 | Pulse output |
| pend_a | output | 1 | Pending flag for reloads from A |
| pend_b | output | 1 | Pending flag for reloads from B |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The counter is driven with a tick on every cycle and with a tick on every third cycle. These two cases separate counting on ticks from counting on clocks. Using unequal A and B values shows whether the high and low phase lengths come from the correct register, and whether an off-by-one exists in the N+1 rule. Stopping the timer just after an A reload and then restarting it shows whether the sequence really returns to A. Stopping it with the output high shows that the output holds its level. Clear pulses are tested on their own and again in the same cycle as a reload, which separates set-wins from clear-wins. The enable inputs are toggled to show that each interrupt line is gated only by its own enable.

// File: rtl/pwm_pkg.sv
// Package: shared types for the alternating-reload PWM timer.
// Assumes: exactly two reload sources, A entered first.
package pwm_pkg;
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } reload_src_e;

    localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/pwm_down_counter.sv
// Module: pwm_down_counter
// Down-counter that steps on enable ticks and reloads from rel_val
// when a tick arrives at zero. Accepts a preset only while stopped.
// Assumes: rel_val is already selected by the reload sequencer.
module pwm_down_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] rel_val,
    output logic [W-1:0] count,
    output logic         uf
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    // Underflow: a running tick while the count sits at zero.
    assign uf = run && tick && (count == ZERO);

    // Count register: reload, decrement, or preset while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else if (run && tick) begin
            count <= uf ? rel_val : (count - ONE);
        end else if (!run && load_en) begin
            count <= load_val;
        end
    end

    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(count));
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count != ZERO) |=> (count == $past(count) - ONE));
    a_r3_reload_on_uf: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (count == $past(rel_val)));
    a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && load_en) |=> (count == $past(load_val)));
endmodule

// File: rtl/pwm_reload_seq.sv
// Module: pwm_reload_seq
// Tracks which reload source the next underflow uses. It flips on each
// underflow and is forced back to A whenever the timer is stopped.
// Assumes: uf is only asserted while run is high.
module pwm_reload_seq
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        uf,
    output reload_src_e sel
);
    // Selector: A on reset or stop, alternate on every underflow.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sel <= SRC_A;
        end else if (uf) begin
            sel <= (sel == SRC_A) ? SRC_B : SRC_A;
        end
    end

    a_r4_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (run && uf) |=> (sel != $past(sel)));
    a_r5_stop_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sel == SRC_A));
endmodule

// File: rtl/pwm_pend_flags.sv
// Module: pwm_pend_flags
// One sticky pending flag per reload source, cleared by a one-cycle
// strobe. When set and clear coincide, the set takes priority.
// Assumes: set strobes are single-cycle reload events.
module pwm_pend_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Flag i: set dominates, otherwise hold unless cleared.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else begin
                pend[i] <= set[i] | (pend[i] & ~clr[i]);
            end
        end

        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> pend[i]);
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !pend[i]);
    end
endmodule

// File: rtl/alt_reload_pwm.sv
// Module: alt_reload_pwm (top)
// PWM timer whose down-counter reloads alternately from A and B. Its
// output inverts on every underflow when enabled. Each reload source
// has its own pending flag and interrupt line.
// Assumes: tick comes from an external prescaler, one clock wide.
module alt_reload_pwm
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         toggle_en,
    input  logic [W-1:0] reload_a,
    input  logic [W-1:0] reload_b,
    input  logic         load_en,
    input  logic [W-1:0] load_value,
    input  logic         clr_a,
    input  logic         clr_b,
    input  logic         ien_a,
    input  logic         ien_b,
    output logic [W-1:0] count,
    output logic         pwm_out,
    output logic         pend_a,
    output logic         pend_b,
    output logic         irq_a,
    output logic         irq_b
);
    reload_src_e          sel;
    logic                 uf;
    logic [W-1:0]         rel_val;
    logic [NUM_SRC-1:0]   set_v;
    logic [NUM_SRC-1:0]   clr_v;
    logic [NUM_SRC-1:0]   pend_v;

    // Reload mux: the sequencer picks A or B.
    assign rel_val = (sel == SRC_A) ? reload_a : reload_b;

    pwm_down_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .load_en(load_en), .load_val(load_value), .rel_val(rel_val),
        .count(count), .uf(uf)
    );

    pwm_reload_seq u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .uf(uf), .sel(sel)
    );

    // Flag set strobes: the source that was reloaded this tick.
    assign set_v = {uf && (sel == SRC_B), uf && (sel == SRC_A)};
    assign clr_v = {clr_b, clr_a};

    pwm_pend_flags #(.N(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .pend(pend_v)
    );

    assign pend_a = pend_v[0];
    assign pend_b = pend_v[1];

    // Interrupt gating: each line masked by its own enable.
    assign irq_a = pend_a & ien_a;
    assign irq_b = pend_b & ien_b;

    // Output pin: invert on underflow when toggling is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
        end else if (uf && toggle_en) begin
            pwm_out <= ~pwm_out;
        end
    end

    a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pwm_out));
    a_r6_hold_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_en |=> $stable(pwm_out));
    a_r6_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && toggle_en) |=> (pwm_out != $past(pwm_out)));
    a_r8_irq_a_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a |-> (pend_a && ien_a));
    a_r8_irq_b_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_b |-> (pend_b && ien_b));
endmodule

// File: tb/alt_reload_pwm_tb.sv
// Directed bench for alt_reload_pwm. A cycle model built from the
// requirements predicts every output after each clock edge.
module alt_reload_pwm_tb;
    localparam int W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, run = 1'b0, toggle_en = 1'b0;
    logic [W-1:0] reload_a = '0, reload_b = '0, load_value = '0;
    logic         load_en = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic         ien_a = 1'b0, ien_b = 1'b0;
    logic [W-1:0] count;
    logic         pwm_out, pend_a, pend_b, irq_a, irq_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state
    logic [W-1:0] m_cnt = '0;
    bit m_sel = 0, m_out = 0, m_pa = 0, m_pb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alt_reload_pwm #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .toggle_en(toggle_en), .reload_a(reload_a), .reload_b(reload_b),
        .load_en(load_en), .load_value(load_value), .clr_a(clr_a),
        .clr_b(clr_b), .ien_a(ien_a), .ien_b(ien_b), .count(count),
        .pwm_out(pwm_out), .pend_a(pend_a), .pend_b(pend_b),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: advance the model on current inputs, then compare.
    task automatic cyc(input string req);
        bit sa, sb;
        sa = 0; sb = 0;
        if (run) begin
            if (tick) begin
                if (m_cnt == 0) begin
                    m_cnt = m_sel ? reload_b : reload_a;
                    if (m_sel) sb = 1; else sa = 1;
                    m_sel = ~m_sel;
                    if (toggle_en) m_out = ~m_out;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end else begin
            m_sel = 0;
            if (load_en) m_cnt = load_value;
        end
        m_pa = sa | (m_pa & ~clr_a);
        m_pb = sb | (m_pb & ~clr_b);
        @(posedge clk); #1;
        chk(req, "count", count, m_cnt);
        chk(req, "pwm_out", pwm_out, m_out);
        chk("R7", "pend_a", pend_a, m_pa);
        chk("R7", "pend_b", pend_b, m_pb);
        chk("R8", "irq_a", irq_a, m_pa & ien_a);
        chk("R8", "irq_b", irq_b, m_pb & ien_b);
    endtask

    task automatic do_reset();
        rst_n = 0; run = 0; tick = 0; toggle_en = 0; load_en = 0;
        clr_a = 0; clr_b = 0; ien_a = 0; ien_b = 0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1;
        m_cnt = '0; m_sel = 0; m_out = 0; m_pa = 0; m_pb = 0;
    endtask

    task automatic preset(input logic [W-1:0] v);
        run = 0; load_en = 1; load_value = v;
        cyc("R9");
        load_en = 0;
    endtask

    // R1: outputs right after reset, and no counting without run.
    task automatic t_reset();
        do_reset();
        chk("R1", "count", count, 0);
        chk("R1", "pwm_out", pwm_out, 0);
        chk("R1", "pend", {pend_a, pend_b, irq_a, irq_b}, 0);
        tick = 1; toggle_en = 1;
        for (int i = 0; i < 3; i++) cyc("R1");
        chk("R1", "idle count", count, 0);
    endtask

    // R9: preset while stopped; preset ignored while running.
    task automatic t_preset();
        do_reset();
        preset(16'd7);
        chk("R9", "preset value", count, 7);
        run = 1; tick = 0; load_en = 1; load_value = 16'h1234;
        cyc("R9");
        chk("R9", "load ignored while running", count, 7);
        load_en = 0; run = 0;
        cyc("R9");
    endtask

    // R3/R4/R6: tick every cycle, measure the high and low phase lengths.
    task automatic t_alternate();
        int hi_len, lo_len, len;
        bit prev;
        do_reset();
        reload_a = 16'd5; reload_b = 16'd2; ien_a = 1; ien_b = 1;
        preset(16'd1);
        run = 1; tick = 1; toggle_en = 1;
        hi_len = 0; lo_len = 0; len = 0; prev = pwm_out;
        for (int i = 0; i < 40; i++) begin
            clr_a = pend_a; clr_b = pend_b;
            cyc("R4");
            if (pwm_out == prev) len++;
            else begin
                if (prev) hi_len = len + 1; else if (i > 3) lo_len = len + 1;
                len = 0;
            end
            prev = pwm_out;
        end
        clr_a = 0; clr_b = 0;
        chk("R3", "high phase ticks (A+1)", hi_len, 6);
        chk("R3", "low phase ticks (B+1)", lo_len, 3);
    endtask

    // R2: tick every third cycle; the count holds between ticks.
    task automatic t_sparse();
        do_reset();
        reload_a = 16'd3; reload_b = 16'd4;
        preset(16'd2);
        run = 1; toggle_en = 1;
        for (int i = 0; i < 45; i++) begin
            tick = (i % 3 == 0);
            cyc("R2");
        end
        tick = 0;
    endtask

    // R5/R6: stop after an A reload with the output high; restart reloads A.
    task automatic t_restart();
        do_reset();
        reload_a = 16'd4; reload_b = 16'd9;
        preset(16'd0);
        run = 1; tick = 1; toggle_en = 1;
        cyc("R4");
        chk("R4", "first reload from A", count, 4);
        chk("R6", "output high after first underflow", pwm_out, 1);
        run = 0;
        for (int i = 0; i < 3; i++) cyc("R6");
        chk("R6", "output held while stopped", pwm_out, 1);
        preset(16'd0);
        run = 1;
        cyc("R5");
        chk("R5", "restart reloads A", count, 4);
        for (int i = 0; i < 12; i++) cyc("R5");
        tick = 0;
    endtask

    // R6: toggling disabled leaves the output alone across underflows.
    task automatic t_no_toggle();
        do_reset();
        reload_a = 16'd1; reload_b = 16'd1;
        preset(16'd0);
        run = 1; tick = 1; toggle_en = 0;
        for (int i = 0; i < 8; i++) cyc("R6");
        chk("R6", "no toggle when disabled", pwm_out, 0);
        tick = 0;
    endtask

    // R7/R8: sticky flags, clear strobe, set-wins collision, enable gating.
    task automatic t_flags();
        do_reset();
        reload_a = 16'd2; reload_b = 16'd2;
        preset(16'd0);
        run = 1; tick = 1; toggle_en = 1; ien_a = 0; ien_b = 1;
        cyc("R7");
        chk("R7", "pend_a after A reload", pend_a, 1);
        chk("R8", "irq_a masked", irq_a, 0);
        tick = 0;
        for (int i = 0; i < 3; i++) cyc("R7");
        chk("R7", "pend_a sticky", pend_a, 1);
        ien_a = 1;
        cyc("R8");
        chk("R8", "irq_a enabled", irq_a, 1);
        clr_a = 1;
        cyc("R7");
        clr_a = 0;
        chk("R7", "pend_a cleared", pend_a, 0);
        tick = 1;
        while (!(m_cnt == 0 && m_sel == 1)) cyc("R7");
        clr_b = 1;
        cyc("R7");
        clr_b = 0;
        chk("R7", "set wins over clear", pend_b, 1);
        chk("R8", "irq_b", irq_b, 1);
        tick = 0;
    endtask

    // Watchdog: fail the run if it hangs.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_preset();
        t_alternate();
        t_sparse();
        t_restart();
        t_no_toggle();
        t_flags();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule